// File: doc/BRIEF.md
# SRAM Bank Clear-on-Start Engine

This block writes a known value into whole SRAM banks, including the matching parity bits, so that later parity checks on those banks never see a word that was never written. It manages six banks. A sweep covers every word of each bank named in a six-bit selection mask, and all selected banks are written in parallel, one word address per clock cycle. A sweep starts in one of two ways. Right after reset, the block starts a sweep of bank 0 by itself. Later sweeps start from a software start pulse that carries its own mask.

The block sits between the system bus and the bank macros. A read or write aimed at a bank that is being swept is held inside the block, and its ready signal stays low until that bank is finished. Accesses to any other bank reach the macro in the same cycle they are presented. A per-bank status vector reports which banks hold a completed fill. A sticky flag records any start request that arrives while a sweep is already running; such a request is dropped.

Top module: `sram_init_engine`

## Requirements
- R1: After a sweep is accepted, every selected bank receives one write per cycle for exactly 1024 consecutive cycles, at word addresses 0, 1, 2 … 1023 in rising order. In the cycle after the last write the bank is no longer driven by the sweep.
- R2: Every sweep write has `mem_we` high and the code word 34'h3_0000_0000. That is all-zero data in bits [31:0], plus odd-parity bits where bit 32 covers data [15:0] and bit 33 covers data [31:16].
- R3: Banks outside the accepted mask get no sweep writes, and their status bits do not change while the sweep runs.
- R4: A request to a bank under sweep keeps `req_ready` low and does not reach that bank. Its write flag, bank, address and data are latched when it is first stalled. In the first cycle after the bank's sweep ends, the latched request is issued to the bank with `req_ready` high, even if the bus values have changed since.
- R5: A request to a bank that is not being swept, with nothing pending, is driven to that bank in the same cycle with `req_ready` high. A write is stored with odd parity per 16-bit half, in the same bit layout as R2.
- R6: After reset is released, bank 0 is swept with no software action. `init_status` reads 6'b000000 during that sweep and 6'b000001 once it ends.
- R7: When the engine is idle, a `sw_start` pulse with a nonzero `sw_mask` begins a sweep of the masked banks at the next clock edge. A pulse with an all-zero mask starts nothing.
- R8: A `sw_start` that arrives while a sweep runs is ignored: the running mask and its end time are unchanged. `start_dropped` goes high on the next cycle and stays high until reset.
- R9: When a sweep starts, the status bits of the selected banks go low, including banks that were already complete. They return high only when the sweep ends. Status bits of other banks are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_start | input | 1 | Software sweep start pulse |
| sw_mask | input | 6 | Banks to sweep, bit i is bank i |
| init_status | output | 6 | Bank i holds a completed fill when bit i is 1 |
| start_dropped | output | 1 | Sticky: a start request arrived during a sweep |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 3 | Target bank index, 0 to 5 |
| req_addr | input | 10 | Word address within the bank |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| mem_en | output | 6 | Per-bank access enable |
| mem_we | output | 6 | Per-bank write enable |
| mem_addr | output | 6x10 | Per-bank word address |
| mem_wdata | output | 6x34 | Per-bank code word, parity in bits [33:32] |

## Verification
The assertions check the following on every cycle:
- a running sweep keeps its mask fixed and clears it right after address 1023;
- sweep addresses rise by one each cycle;
- a bank under sweep is never granted to the bus and only ever sees the zero code word;
- a held request keeps ready low and is issued as soon as its bank frees;
- status and running mask never overlap;
- a start during a sweep always raises the sticky flag.

Only the bench scenarios can show the end-to-end results:
- the exact 1024-cycle length and the status values seen from outside;
- that the latched address and data, not later bus values, reach the bank;
- that unselected banks stay untouched;
- that an all-zero mask starts nothing.

// File: rtl/sram_init_pkg.sv
package sram_init_pkg;
    parameter int NUM_BANKS  = 6;
    parameter int BANK_WORDS = 1024;
    parameter int DATA_W     = 32;

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int ADDR_W = $clog2(BANK_WORDS);
    localparam int HALF_W = DATA_W / 2;
    localparam int CODE_W = DATA_W + 2;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BANK_WORDS - 1);
    localparam logic [NUM_BANKS-1:0] AUTO_MASK = NUM_BANKS'(1);

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

    typedef struct packed {
        logic              write;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    // odd parity per half word, upper half in the top bit
    function automatic logic [CODE_W-1:0] parity_encode(input logic [DATA_W-1:0] d);
        return {~^d[DATA_W-1:HALF_W], ~^d[HALF_W-1:0], d};
    endfunction

    localparam logic [CODE_W-1:0] CLEAR_CODE = {2'b11, {DATA_W{1'b0}}};

    function automatic logic [NUM_BANKS-1:0] bank_onehot(input logic [BANK_W-1:0] b);
        logic [NUM_BANKS-1:0] oh;
        for (int i = 0; i < NUM_BANKS; i++) oh[i] = (b == BANK_W'(i));
        return oh;
    endfunction
endpackage

// File: rtl/sram_init_seq.sv
module sram_init_seq
    import sram_init_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sw_start,
    input  logic [NUM_BANKS-1:0] sw_mask,
    output logic [NUM_BANKS-1:0] busy,
    output logic [ADDR_W-1:0]    sweep_addr,
    output logic [NUM_BANKS-1:0] status,
    output logic                 dropped
);
    seq_state_e state;
    logic       auto_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            sweep_addr <= '0;
            busy       <= '0;
            status     <= '0;
            dropped    <= 1'b0;
            auto_go    <= 1'b1;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    sweep_addr <= '0;
                    if (auto_go) begin
                        auto_go <= 1'b0;
                        state   <= SEQ_RUN;
                        busy    <= AUTO_MASK;
                        status  <= status & ~AUTO_MASK;
                        if (sw_start) dropped <= 1'b1;
                    end else if (sw_start && (sw_mask != '0)) begin
                        state  <= SEQ_RUN;
                        busy   <= sw_mask;
                        status <= status & ~sw_mask;
                    end
                end
                default: begin
                    if (sw_start) dropped <= 1'b1;
                    if (sweep_addr == LAST_ADDR) begin
                        state      <= SEQ_IDLE;
                        status     <= status | busy;
                        busy       <= '0;
                        sweep_addr <= '0;
                    end else begin
                        sweep_addr <= sweep_addr + 1'b1;
                    end
                end
            endcase
        end
    end

    // R1
    sweep_end_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RUN && sweep_addr == LAST_ADDR) |=> (busy == '0));
    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RUN && sweep_addr != LAST_ADDR) |=> $stable(busy));
    // R8
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RUN && sw_start) |=> dropped);
    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (status & busy) == '0);
endmodule

// File: rtl/sram_init_arb.sv
module sram_init_arb
    import sram_init_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] busy,
    input  logic                 req_valid,
    input  bus_req_t             req,
    output logic                 grant,
    output bus_req_t             sel,
    output logic                 req_ready
);
    bus_req_t pend;
    logic     pend_v;
    logic     req_busy, pend_busy;

    assign req_busy  = |(bank_onehot(req.bank) & busy);
    assign pend_busy = |(bank_onehot(pend.bank) & busy);

    always_comb begin
        grant     = 1'b0;
        req_ready = 1'b0;
        sel       = req;
        if (pend_v) begin
            sel = pend;
            if (!pend_busy) begin
                grant     = 1'b1;
                req_ready = 1'b1;
            end
        end else if (req_valid && !req_busy) begin
            grant     = 1'b1;
            req_ready = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend   <= '0;
        end else if (pend_v) begin
            if (!pend_busy) pend_v <= 1'b0;
        end else if (req_valid && req_busy) begin
            pend_v <= 1'b1;
            pend   <= req;
        end
    end

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_v && pend_busy) |-> !req_ready);
    // R4
    pend_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_v && !pend_busy) |=> !pend_v);
endmodule

// File: rtl/sram_init_bank_port.sv
module sram_init_bank_port
    import sram_init_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] sweep_addr,
    input  logic              grant,
    input  bus_req_t          sel,
    output logic              en,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [CODE_W-1:0] wdata
);
    logic hit;
    assign hit = grant && (sel.bank == BANK_W'(IDX));

    always_comb begin
        if (busy_i) begin
            en    = 1'b1;
            we    = 1'b1;
            addr  = sweep_addr;
            wdata = CLEAR_CODE;
        end else begin
            en    = hit;
            we    = hit && sel.write;
            addr  = sel.addr;
            wdata = parity_encode(sel.data);
        end
    end

    // R4
    no_busy_grant_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !hit);
    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && $past(busy_i)) |-> (addr == $past(addr) + 1'b1));
    // R2
    clear_word_chk: assert property (@(posedge clk) disable iff (rst)
        (en && busy_i) |-> (we && wdata == {2'b11, {DATA_W{1'b0}}}));
endmodule

// File: rtl/sram_init_engine.sv
module sram_init_engine
    import sram_init_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              sw_start,
    input  logic [NUM_BANKS-1:0]              sw_mask,
    output logic [NUM_BANKS-1:0]              init_status,
    output logic                              start_dropped,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [BANK_W-1:0]                 req_bank,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [DATA_W-1:0]                 req_wdata,
    output logic                              req_ready,
    output logic [NUM_BANKS-1:0]              mem_en,
    output logic [NUM_BANKS-1:0]              mem_we,
    output logic [NUM_BANKS-1:0][ADDR_W-1:0]  mem_addr,
    output logic [NUM_BANKS-1:0][CODE_W-1:0]  mem_wdata
);
    logic [NUM_BANKS-1:0] busy;
    logic [ADDR_W-1:0]    sweep_addr;
    logic                 grant;
    bus_req_t             req, sel;

    assign req = '{write: req_write, bank: req_bank, addr: req_addr, data: req_wdata};

    sram_init_seq u_seq (
        .clk(clk), .rst(rst), .sw_start(sw_start), .sw_mask(sw_mask),
        .busy(busy), .sweep_addr(sweep_addr), .status(init_status),
        .dropped(start_dropped)
    );

    sram_init_arb u_arb (
        .clk(clk), .rst(rst), .busy(busy), .req_valid(req_valid), .req(req),
        .grant(grant), .sel(sel), .req_ready(req_ready)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        sram_init_bank_port #(.IDX(i)) u_port (
            .clk(clk), .rst(rst), .busy_i(busy[i]), .sweep_addr(sweep_addr),
            .grant(grant), .sel(sel), .en(mem_en[i]), .we(mem_we[i]),
            .addr(mem_addr[i]), .wdata(mem_wdata[i])
        );
    end
endmodule

// File: tb/sram_init_engine_test.sv
module sram_init_engine_test;
    import sram_init_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_start = 1'b0;
    logic [5:0] sw_mask = '0;
    logic [5:0] init_status;
    logic start_dropped;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [2:0] req_bank = '0;
    logic [9:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready;
    logic [5:0] mem_en, mem_we;
    logic [5:0][9:0] mem_addr;
    logic [5:0][33:0] mem_wdata;

    int tests = 0, fails = 0;
    bit done = 0;
    localparam logic [33:0] ZERO_CODE = 34'h3_0000_0000;

    always #5 clk = ~clk;

    sram_init_engine uut (
        .clk(clk), .rst(rst), .sw_start(sw_start), .sw_mask(sw_mask),
        .init_status(init_status), .start_dropped(start_dropped),
        .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic [33:0] exp_code(input logic [31:0] d);
        logic hi_odd = ~(^d[31:16]);
        logic lo_odd = ~(^d[15:0]);
        return {hi_odd, lo_odd, d};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(init_status == 6'b0 && start_dropped == 1'b0, "R8 reset state status/flag",
            {init_status, start_dropped}, 0);
        chk(mem_en == 6'b0, "R6 no bank access in reset", mem_en, 0);
        rst = 1'b0;
    endtask

    // R6 R1 R2 R3: automatic bank 0 sweep
    task automatic t_autoinit();
        int seq_err = 0, word_err = 0, other_err = 0, stat_err = 0;
        for (int k = 0; k < 1024; k++) begin
            @(negedge clk);
            if (!mem_en[0] || mem_addr[0] != 10'(k)) seq_err++;
            if (!mem_we[0] || mem_wdata[0] != ZERO_CODE) word_err++;
            if (mem_en[5:1] != 5'b0) other_err++;
            if (init_status != 6'b0) stat_err++;
        end
        chk(seq_err == 0, "R1 auto sweep address order", seq_err, 0);
        chk(word_err == 0, "R2 auto sweep code word", word_err, 0);
        chk(other_err == 0, "R3 other banks untouched", other_err, 0);
        chk(stat_err == 0, "R6 status low during auto sweep", stat_err, 0);
        @(negedge clk);
        chk(init_status == 6'b000001, "R6 bank 0 complete", init_status, 6'b000001);
        chk(mem_en == 6'b0, "R1 sweep stops after 1024", mem_en, 0);
    endtask

    // R5: idle pass-through
    task automatic t_passthru();
        req_valid = 1; req_write = 1; req_bank = 3; req_addr = 5; req_wdata = 32'h1;
        #1;
        chk(mem_en == 6'b001000 && mem_we[3] && mem_addr[3] == 10'd5 && req_ready,
            "R5 write pass", {mem_en, mem_addr[3], req_ready}, {6'b001000, 10'd5, 1'b1});
        chk(mem_wdata[3] == exp_code(32'h1), "R5 write parity", mem_wdata[3], exp_code(32'h1));
        req_write = 0; req_bank = 4; req_addr = 9;
        #1;
        chk(mem_en == 6'b010000 && !mem_we[4] && mem_addr[4] == 10'd9 && req_ready,
            "R5 read pass", {mem_en, mem_we, req_ready}, {6'b010000, 6'b0, 1'b1});
        req_valid = 0;
        #1;
        chk(mem_en == 6'b0 && !req_ready, "R5 idle after drop", {mem_en, req_ready}, 0);
        @(negedge clk);
    endtask

    // R7 R3 R4 R5 R8: software sweep with stall, pass and dropped start
    task automatic t_sweep_stall();
        int seq_err = 0, other_err = 0, stat_err = 0, rdy_err = 0;
        sw_start = 1; sw_mask = 6'b010110;
        @(negedge clk);
        sw_start = 0;
        chk(mem_en == 6'b010110, "R7 sweep begins next edge", mem_en, 6'b010110);
        for (int k = 0; k < 1024; k++) begin
            if (mem_addr[1] != 10'(k) || mem_addr[4] != 10'(k) || mem_wdata[2] != ZERO_CODE) seq_err++;
            if (mem_en[3] || mem_en[5]) other_err++;
            if (init_status != 6'b000001) stat_err++;
            if (k > 20 && req_ready) rdy_err++;
            if (k == 10) begin
                req_valid = 1; req_write = 0; req_bank = 0; req_addr = 3;
                #1;
                chk(mem_en[0] && !mem_we[0] && mem_addr[0] == 10'd3 && req_ready,
                    "R5 pass during sweep", {mem_en, req_ready}, {6'b010111, 1'b1});
                req_valid = 0;
            end
            if (k == 20) begin
                req_valid = 1; req_write = 1; req_bank = 2; req_addr = 7; req_wdata = 32'hA5;
                #1;
                chk(!req_ready && mem_addr[2] == 10'd20 && mem_wdata[2] == ZERO_CODE,
                    "R4 stall keeps bank on sweep", {req_ready, mem_addr[2]}, {1'b0, 10'd20});
            end
            if (k == 25) begin req_addr = 9; req_wdata = 32'h0; end
            if (k == 30) begin sw_start = 1; sw_mask = 6'b100000; end
            if (k == 31) begin
                sw_start = 0;
                chk(start_dropped == 1'b1, "R8 flag on busy start", start_dropped, 1);
            end
            if (k < 1023) @(negedge clk);
        end
        chk(seq_err == 0, "R1 sweep address and word", seq_err, 0);
        chk(other_err == 0, "R3 unselected banks idle", other_err, 0);
        chk(stat_err == 0, "R9 status during sweep", stat_err, 0);
        chk(rdy_err == 0, "R4 ready low while held", rdy_err, 0);
        @(negedge clk);
        chk(init_status == 6'b010111, "R8 dropped mask not run", init_status, 6'b010111);
        chk(mem_en[2] && mem_we[2] && mem_addr[2] == 10'd7 && req_ready,
            "R4 held access issued", {mem_en[2], mem_addr[2], req_ready}, {1'b1, 10'd7, 1'b1});
        chk(mem_wdata[2] == exp_code(32'hA5), "R4 latched data", mem_wdata[2], exp_code(32'hA5));
        #1 req_valid = 0;
        @(negedge clk);
        chk(mem_en == 6'b0 && !req_ready, "R4 single issue", {mem_en, req_ready}, 0);
        chk(start_dropped == 1'b1, "R8 flag sticky", start_dropped, 1);
    endtask

    // R7 R9 R1: zero mask then re-sweep of completed banks
    task automatic t_reinit();
        int n = 0;
        sw_start = 1; sw_mask = 6'b0;
        @(negedge clk);
        sw_start = 0;
        chk(mem_en == 6'b0 && init_status == 6'b010111, "R7 zero mask starts nothing",
            {mem_en, init_status}, {6'b0, 6'b010111});
        sw_start = 1; sw_mask = 6'b000011;
        @(negedge clk);
        sw_start = 0;
        chk(init_status == 6'b010100, "R9 reselected status low", init_status, 6'b010100);
        while (init_status[0] == 1'b0 && n < 2000) begin
            n++;
            @(negedge clk);
        end
        chk(n == 1024, "R1 sweep length", n, 1024);
        chk(init_status == 6'b010111, "R9 status restored", init_status, 6'b010111);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_autoinit();
        t_passthru();
        t_sweep_stall();
        t_reinit();
        do_reset();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule